// File: doc/BRIEF.md
# I2C Write-Only Target with Byte-Wait Stretch

This block sits on an open-drain I2C bus as a target that only accepts writes. After a start condition it shifts in the first byte and compares its upper seven bits with a configurable own address. When the address matches and the direction bit says "write", it acknowledges. It then takes in data bytes, most significant bit first. For each data byte it can acknowledge in hardware during the ninth clock. From the falling edge of that ninth clock it pulls SCL low, so the master waits until local logic has taken the byte.

The received byte leaves the block on a valid/ready stream. `rx_valid` rises together with the SCL hold and stays high, with `rx_data` unchanged, until a cycle in which `rx_ready` is also high. That handshake cycle is the wait release. On the following edge SCL is let go and the bus moves on. Back-pressure from `rx_ready` therefore becomes clock stretching on the bus, with no byte lost and no extra buffer.

Two sticky interrupt causes are kept: end of byte and stop condition. Each cause is cleared by writing a one to it, and each is gated by its own enable into a single interrupt line. Both bus lines pass through a two-flop synchroniser and an edge detector running on the system clock.

Top module: `i2c_wr_target`

## Requirements
- R1: While reset is asserted, and right after it is released, `scl_oe`, `sda_oe`, `rx_valid`, `irq_cause` and `irq` are all 0.
- R2: A start condition (SDA falls while SCL is high) clears the bit count and begins address reception from any state, including partway through a byte.
- R3: The first byte after a start is taken MSB first. Bits 7..1 are compared with `own_addr`, and bit 0 (the direction bit) must be 0. On a match the target drives ACK (`sda_oe`=1) from the falling edge of the 8th SCL clock to the falling edge of the 9th. The address byte causes no wait and no interrupt.
- R4: When the address byte does not match, or its direction bit is 1, the target drives no ACK, holds no SCL wait, delivers no byte and ignores the bus until the next start or stop.
- R5: Data bits are sampled on rising SCL edges, MSB first. Each completed data byte appears on `rx_data`.
- R6: With `ack_en`=1, each data byte is acknowledged over the same window as in R3. With `ack_en`=0 the target never drives SDA for a data byte, but it still waits and delivers the byte.
- R7: At the falling edge of a data byte's 9th clock, `scl_oe` and `rx_valid` rise together. Both stay high, and `rx_data` stays unchanged, until a cycle with `rx_valid`=1 and `rx_ready`=1. Both are 0 on the next edge.
- R8: Cause bit 0 (`irq_cause[0]`, end of byte) is set at each data byte's 9th-clock falling edge.
- R9: A stop condition (SDA rises while SCL is high) sets cause bit 1 (`irq_cause[1]`), releases both lines and returns the target to idle.
- R10: A set cause bit stays set until a cycle with the matching `irq_clr` bit at 1. If a set and a clear reach the same bit in the same cycle, the set wins.
- R11: `irq` is 1 exactly when some bit of `irq_cause & irq_en` is 1.
- R12: Each line outputs' response to a bus edge (ACK drive, SCL hold) takes effect on the third rising clock edge after the line changes. A cause bit follows one edge after its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the pad |
| sda_i | input | 1 | SDA level seen on the pad |
| scl_oe | output | 1 | 1 pulls SCL low (wait state) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| own_addr | input | 7 | Own 7-bit target address |
| ack_en | input | 1 | Acknowledge data bytes in hardware |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | Byte on `rx_data` is waiting |
| rx_ready | input | 1 | Local side takes the byte; releases the wait |
| irq_en | input | 2 | Per-cause interrupt enable (bit 0 end of byte, bit 1 stop) |
| irq_clr | input | 2 | Write-one-to-clear strobes for the cause bits |
| irq_cause | output | 2 | Sticky cause bits (bit 0 end of byte, bit 1 stop) |
| irq | output | 1 | OR of enabled causes |

## Verification
A bus edge reaches the logic through two synchroniser flops, so `sda_oe`, `scl_oe`, `rx_valid` and `rx_data` change on the third rising edge after the line moves. The cause bits change one edge after that, and `irq` follows them within the same cycle. A handshake drops `scl_oe` and `rx_valid` on the next edge. The bench master changes the lines on falling clock edges. A behavioural model advances on each rising edge from line samples delayed by the same two stages. Outputs are compared with it 1 ns after every rising edge, and separate checks measure the third-edge ACK and hold latency directly.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = BYTE_W - 1;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int N_CAUSE = 2;
  localparam int C_EOB   = 0;
  localparam int C_STOP  = 1;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_AACK,
    RX_DATA,
    RX_DACK,
    RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '1;
    else        prev_q <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/i2cs_rx_core.sv
module i2cs_rx_core
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              rx_ready,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              eob_pulse,
  output logic              stop_pulse
);
  rx_state_t         state_q;
  logic [CNT_W-1:0]  bits_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              start_cond, stop_cond, byte_full, addr_hit;

  // SCL high on both samples while SDA moves
  assign start_cond = scl_s & ~scl_rise & sda_fall;
  assign stop_cond  = scl_s & ~scl_rise & sda_rise;
  assign byte_full  = (bits_q == CNT_W'(BYTE_W));
  assign addr_hit   = (shreg_q[BYTE_W-1:1] == own_addr) && !shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      bits_q     <= '0;
      shreg_q    <= '0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      eob_pulse  <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      eob_pulse  <= 1'b0;
      stop_pulse <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (stop_cond) begin
        state_q    <= RX_IDLE;
        scl_oe     <= 1'b0;
        sda_oe     <= 1'b0;
        stop_pulse <= 1'b1;
      end else if (start_cond) begin
        state_q <= RX_ADDR;
        bits_q  <= '0;
        scl_oe  <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state_q)
          RX_ADDR, RX_DATA: begin
            if (scl_rise && !byte_full) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
              bits_q  <= bits_q + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (state_q == RX_ADDR) begin
                if (addr_hit) begin
                  sda_oe  <= 1'b1;
                  state_q <= RX_AACK;
                end else begin
                  state_q <= RX_IDLE;
                end
              end else begin
                sda_oe  <= ack_en;
                rx_data <= shreg_q;
                state_q <= RX_DACK;
              end
            end
          end
          RX_AACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            bits_q  <= '0;
            state_q <= RX_DATA;
          end
          RX_DACK: if (scl_fall) begin
            sda_oe    <= 1'b0;
            scl_oe    <= 1'b1;
            rx_valid  <= 1'b1;
            eob_pulse <= 1'b1;
            state_q   <= RX_HOLD;
          end
          RX_HOLD: if (rx_ready) begin
            scl_oe  <= 1'b0;
            bits_q  <= '0;
            state_q <= RX_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  AST_HOLD_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n) scl_oe |-> rx_valid); // R7
  AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R7
  AST_NO_ACK_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) scl_oe |-> !sda_oe); // R6
  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n) stop_cond |=> (!scl_oe && !sda_oe && stop_pulse)); // R9
  AST_EOB_AT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) eob_pulse |-> (scl_oe && rx_valid)); // R8
endmodule

// File: rtl/i2cs_irq.sv
module i2cs_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] cause,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cause[i] <= 1'b0;
      else if (set[i]) cause[i] <= 1'b1;
      else if (clr[i]) cause[i] <= 1'b0;
  end

  assign irq = |(cause & en);

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) |(cause & ~clr) |=> ((cause & $past(cause & ~clr)) == $past(cause & ~clr))); // R10
  AST_CAUSE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) |set |=> ((cause & $past(set)) == $past(set))); // R10
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               scl_oe,
  output logic               sda_oe,
  input  logic [6:0]         own_addr,
  input  logic               ack_en,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  input  logic [1:0]         irq_en,
  input  logic [1:0]         irq_clr,
  output logic [1:0]         irq_cause,
  output logic               irq
);
  localparam int LINES = 2;
  localparam int L_SCL = 0;
  localparam int L_SDA = 1;

  logic [LINES-1:0]   lvl, rise, fall;
  logic               eob_p, stop_p;
  logic [N_CAUSE-1:0] set_vec;

  i2cs_line_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({sda_i, scl_i}),
    .level (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  i2cs_rx_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (lvl[L_SCL]),
    .sda_s      (lvl[L_SDA]),
    .scl_rise   (rise[L_SCL]),
    .scl_fall   (fall[L_SCL]),
    .sda_rise   (rise[L_SDA]),
    .sda_fall   (fall[L_SDA]),
    .own_addr   (own_addr),
    .ack_en     (ack_en),
    .rx_ready   (rx_ready),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .eob_pulse  (eob_p),
    .stop_pulse (stop_p)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[C_EOB]  = eob_p;
    set_vec[C_STOP] = stop_p;
  end

  i2cs_irq #(.N(N_CAUSE)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_vec),
    .clr   (irq_clr),
    .en    (irq_en),
    .cause (irq_cause),
    .irq   (irq)
  );
endmodule

// File: tb/sim_i2c_wr_target.sv
`timescale 1ns/1ps
module sim_i2c_wr_target;
  localparam int Q = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, rx_valid, irq, ack_en = 1'b1, rx_ready = 1'b0;
  logic [6:0] own_addr = 7'h5A;
  logic [7:0] rx_data;
  logic [1:0] irq_en = 2'b11, irq_clr = 2'b00, irq_cause;
  wire scl_line = !(m_scl_low || scl_oe);
  wire sda_line = !(m_sda_low || sda_oe);

  i2c_wr_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .ack_en(ack_en),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_cause(irq_cause), .irq(irq));

  int vectors = 0, miscompares = 0;
  int rdy_delay = 0, rdy_cnt = 0;
  int lat_sda, lat_scl;
  int got[$];
  int sent[$];

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: line history delayed like the pad synchroniser
  bit hc[3], hd[3];
  int ms, mn, msh, e_data;
  bit e_scl, e_sda, e_val;
  bit [1:0] e_cause, e_pend;
  bit s_c, p_c, s_d, p_d;
  always @(posedge clk) begin
    if (!rst_n) begin
      hc = '{1, 1, 1}; hd = '{1, 1, 1};
      ms = 0; mn = 0; msh = 0; e_data = 0;
      e_scl = 0; e_sda = 0; e_val = 0; e_cause = 0; e_pend = 0;
    end else begin
      s_c = hc[1]; p_c = hc[2]; s_d = hd[1]; p_d = hd[2];
      e_cause = (e_cause & ~irq_clr) | e_pend;
      e_pend = 0;
      if (e_val && rx_ready) e_val = 0;
      if (s_c && p_c && !p_d && s_d) begin
        ms = 0; e_sda = 0; e_scl = 0; e_pend[1] = 1;
      end else if (s_c && p_c && p_d && !s_d) begin
        ms = 1; mn = 0; e_sda = 0; e_scl = 0;
      end else begin
        case (ms)
          1, 3: begin
            if (s_c && !p_c && mn < 8) begin
              msh = ((msh << 1) | int'(s_d)) & 255; mn++;
            end else if (!s_c && p_c && mn == 8) begin
              if (ms == 1) begin
                if ((msh >> 1) == int'(own_addr) && (msh & 1) == 0) begin e_sda = 1; ms = 2; end
                else ms = 0;
              end else begin
                e_sda = ack_en; e_data = msh; ms = 4;
              end
            end
          end
          2: if (!s_c && p_c) begin e_sda = 0; mn = 0; ms = 3; end
          4: if (!s_c && p_c) begin e_sda = 0; e_scl = 1; e_val = 1; e_pend[0] = 1; ms = 5; end
          5: if (rx_ready) begin e_scl = 0; mn = 0; ms = 3; end
          default: ;
        endcase
      end
      hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = scl_line;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = sda_line;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R6 sda_oe", sda_oe, e_sda);
      chk("R7 scl_oe", scl_oe, e_scl);
      chk("R7 rx_valid", rx_valid, e_val);
      if (e_val) chk("R5 rx_data", rx_data, e_data);
      chk("R8 irq_cause[0]", irq_cause[0], e_cause[0]);
      chk("R9 irq_cause[1]", irq_cause[1], e_cause[1]);
      chk("R11 irq", irq, |(e_cause & irq_en));
    end
  end

  // Local consumer
  initial begin
    forever begin
      @(negedge clk);
      if (rx_ready) rx_ready = 1'b0;
      else if (rx_valid) begin
        if (rdy_cnt >= rdy_delay) begin
          rx_ready = 1'b1; got.push_back(rx_data); rdy_cnt = 0;
        end else rdy_cnt++;
      end
    end
  end

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    do @(negedge clk); while (!scl_line);
  endtask

  task automatic m_bit(input bit b, output bit seen);
    bit was_sda, was_scl;
    m_sda_low = !b;
    waitn(Q);
    scl_up();
    waitn(Q);
    seen = sda_line;
    waitn(Q);
    was_sda = sda_oe; was_scl = scl_oe;
    m_scl_low = 1'b1;
    lat_sda = -1; lat_scl = -1;
    for (int i = 1; i <= Q; i++) begin
      @(negedge clk);
      if (lat_sda < 0 && sda_oe && !was_sda) lat_sda = i;
      if (lat_scl < 0 && scl_oe && !was_scl) lat_scl = i;
    end
  endtask

  task automatic m_byte(int v, bit exp_ack, string tag, bit data_byte);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(v[i], s);
      if (i == 0 && exp_ack) chk("R12 ack latency", lat_sda, 3);
    end
    m_bit(1'b1, s);
    chk(tag, !s, exp_ack);
    if (data_byte) chk("R12 hold latency", lat_scl, 3);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; waitn(Q);
    scl_up(); waitn(Q);
    m_sda_low = 1'b1; waitn(Q);
    m_scl_low = 1'b1; waitn(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; waitn(Q);
    scl_up(); waitn(Q);
    m_sda_low = 1'b0; waitn(2 * Q);
  endtask

  task automatic check_bytes();
    chk("R5 byte count", got.size(), sent.size());
    while (got.size() > 0 && sent.size() > 0) chk("R5 byte value", got.pop_front(), sent.pop_front());
    got.delete(); sent.delete();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    waitn(3);
    chk("R1 scl_oe in reset", scl_oe, 0);
    chk("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 irq_cause", irq_cause, 0);
    chk("R1 irq", irq, 0);
    waitn(10);

    // Matched write, several byte patterns and consumer delays
    m_start();
    m_byte({7'h5A, 1'b0}, 1, "R3 address ack", 0);
    foreach (sent[i]) ;
    rdy_delay = 0;  m_byte(8'hA5, 1, "R6 data ack", 1); sent.push_back(8'hA5);
    rdy_delay = 37; m_byte(8'h3C, 1, "R6 data ack", 1); sent.push_back(8'h3C);
    rdy_delay = 5;  m_byte(8'hFF, 1, "R6 data ack", 1); sent.push_back(8'hFF);
    m_byte(8'h00, 1, "R6 data ack", 1); sent.push_back(8'h00);
    m_stop();
    check_bytes();
    chk("R9 stop cause", irq_cause[1], 1);
    chk("R10 eob sticky", irq_cause[0], 1);

    // Write-one-to-clear, one bit at a time
    irq_clr = 2'b01; @(negedge clk); irq_clr = 2'b00; waitn(2);
    chk("R10 eob cleared", irq_cause, 2'b10);
    irq_en = 2'b01; waitn(1);
    chk("R11 stop masked", irq, 0);
    irq_clr = 2'b10; @(negedge clk); irq_clr = 2'b00; waitn(2);
    chk("R10 stop cleared", irq_cause, 0);

    // Address mismatch and read direction are ignored
    m_start();
    m_byte({7'h23, 1'b0}, 0, "R4 wrong address no ack", 0);
    m_byte(8'h12, 0, "R4 ignored byte no ack", 0);
    chk("R4 no byte delivered", got.size(), 0);
    chk("R4 no eob", irq_cause[0], 0);
    m_stop();
    m_start();
    m_byte({7'h5A, 1'b1}, 0, "R4 read direction no ack", 0);
    m_byte(8'h77, 0, "R4 ignored byte no ack", 0);
    chk("R4 no byte delivered", got.size(), 0);
    m_stop();

    // ACK disabled: byte still held and delivered, clear held during set
    ack_en = 1'b0; irq_en = 2'b11; rdy_delay = 12;
    irq_clr = 2'b01;
    m_start();
    m_byte({7'h5A, 1'b0}, 1, "R3 address ack with ack_en=0", 0);
    m_byte(8'h81, 0, "R6 no data ack", 1); sent.push_back(8'h81);
    irq_clr = 2'b00;
    m_stop();
    check_bytes();
    ack_en = 1'b1;

    // Repeated start part way through a byte
    own_addr = 7'h11; rdy_delay = 2;
    m_start();
    m_byte({7'h11, 1'b0}, 1, "R3 address ack", 0);
    m_byte(8'h6E, 1, "R6 data ack", 1); sent.push_back(8'h6E);
    begin
      bit s;
      m_bit(1'b0, s); m_bit(1'b1, s);
    end
    m_start();
    m_byte({7'h11, 1'b0}, 1, "R2 address ack after restart", 0);
    m_byte(8'hC3, 1, "R2 data ack after restart", 1); sent.push_back(8'hC3);
    m_stop();
    check_bytes();
    waitn(20);
    summary();
  end
endmodule